// File: doc/BRIEF.md
# Counter Configuration Register Access Checker

This block sits beside the system-register decoder of a processor core and rules on one kind of access: a read or write to one of up to 31 event-counter configuration registers. It receives the five encoding fields of the instruction, a direction flag, the current privilege level (0 to 3), and the control bits that govern such accesses. These are the user enables and user read-only bit set at level 0, the host redirect, fine-grained and monitor trap bits set at level 2, and the monitor trap bit set at level 3. It also receives a per-counter user access mask, the number of counters built, and the number that level 2 makes accessible.

From these it picks one outcome: perform the access, read as zero, ignore the write, raise an undefined-instruction exception, or trap to a higher level. For a trap it also gives the target level and the 8-bit syndrome class. The decision and the decoded counter index appear one clock after the request, with a valid strobe. Register storage and exception entry are handled elsewhere. The block only tells the core what to do.

Top module: `ctrcfg_access_check`

## Requirements
- R1: A request matches only when op0=2'b11, op1=3'b011, crn=4'b1110 and crm[3:2]=2'b11. The counter index reported on counterIdx is {crm[1:0], op2[2:0]}.
- R2: When the index is at or above implCount, or at or above the number of counter slots (31), the outcome is undefined (outKind=3) at every privilege level, whatever the other controls are.
- R3: At level 0, when userEnAll and userEnMasked are both 0, the access traps to level 1. It traps to level 2 instead when hostRedirect and el2Enabled are both 1. This check comes before every check except R2.
- R4: Every trap (outKind=4) reports syndromeClass 8'h18 and a trapLevel above the current level. Every other outcome reports syndromeClass 0 and trapLevel 0.
- R5: At levels 0 and 1, with el2Enabled=1, the access traps to level 2 if any of these holds: the fine-grained trap bit for its direction is set (fgRdTrap for reads, fgWrTrap for writes), l2MonTrap is set, or the index is at or above accCount. The fine-grained bit for the other direction has no effect. With el2Enabled=0 none of these three conditions applies. Only when none of them traps does l3MonTrap=1 trap to level 3.
- R6: At level 2, only l3MonTrap is checked, and it traps to level 3. At level 3, every in-range access is performed (outKind=0).
- R7: At level 0, when userEnMasked=1 and no trap applies: a read of a counter whose userAccessMask bit is 0 reads as zero (outKind=1). A write is ignored (outKind=2) when that mask bit is 0 or when userReadOnly=1. Otherwise the access is performed.
- R8: The outputs are registered. outValid goes high the cycle after a matching request with inValid=1. A non-matching request, or no request, gives outValid=0 with every other output at zero. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A register access request is present |
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field CRn |
| crm | input | 4 | Encoding field CRm |
| op2 | input | 3 | Encoding field op2 |
| isRead | input | 1 | 1 for a read, 0 for a write |
| curLevel | input | 2 | Current privilege level |
| el2Enabled | input | 1 | Level 2 is enabled in the current state |
| hostRedirect | input | 1 | Redirects level-0 user-enable traps to level 2 |
| userEnAll | input | 1 | Level-0 full access enable |
| userEnMasked | input | 1 | Level-0 per-counter masked access enable |
| userReadOnly | input | 1 | Masked level-0 access is read only |
| userAccessMask | input | 31 | Per-counter level-0 access bits |
| fgRdTrap | input | 1 | Fine-grained read trap to level 2 |
| fgWrTrap | input | 1 | Fine-grained write trap to level 2 |
| l2MonTrap | input | 1 | Level-2 monitor trap bit |
| l3MonTrap | input | 1 | Level-3 monitor trap bit |
| implCount | input | 6 | Number of counters built |
| accCount | input | 6 | Number of counters accessible below level 2 |
| outValid | output | 1 | Decision valid |
| outKind | output | 3 | 0 perform, 1 read-zero, 2 write-ignore, 3 undefined, 4 trap |
| trapLevel | output | 2 | Target level of a trap |
| syndromeClass | output | 8 | Syndrome class of a trap |
| counterIdx | output | 5 | Decoded counter index |

## Verification
The hardest outcomes to reach are the read-as-zero and write-ignore results at level 0. They need a matching encoding, an in-range index, no user-enable trap, level 2 either disabled or with all three of its conditions clear, no level-3 monitor trap, and the right mask bit. With uniform random inputs this combination is rare. The random stimulus therefore sets each trap bit only one time in four, sets the counts to their maximum half of the time, and gives the mask bits a 50% chance. Directed cases also build each of these two results explicitly, next to the undefined-index boundary at index 30 and 31.

// File: rtl/ctrcfg_pkg.sv
package ctrcfg_pkg;

  typedef enum logic [2:0] {
    KIND_PERFORM = 3'd0,
    KIND_RAZ     = 3'd1,
    KIND_WI      = 3'd2,
    KIND_UNDEF   = 3'd3,
    KIND_TRAP    = 3'd4
  } accessKind_e;

  // Conditions the datapath derives from the encoding and counts
  typedef struct packed {
    logic match;
    logic overImpl;
    logic overAcc;
    logic userBit;
  } accessCond_t;

  // Strobes from control to datapath
  typedef struct packed {
    accessKind_e kind;
    logic [1:0]  trapLevel;
    logic        isTrap;
  } accessDecision_t;

  localparam logic [1:0] SEL_OP0     = 2'b11;
  localparam logic [2:0] SEL_OP1     = 3'b011;
  localparam logic [3:0] SEL_CRN     = 4'b1110;
  localparam logic [1:0] SEL_CRM_TOP = 2'b11;

endpackage

// File: rtl/ctrcfg_decode.sv
module ctrcfg_decode
  import ctrcfg_pkg::*;
#(
  parameter int NUM_CTR = 31,
  parameter int IDX_W = 5,
  parameter int CNT_W = 6,
  parameter logic [7:0] SYN_CLASS = 8'h18
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [1:0]         op0,
  input  logic [2:0]         op1,
  input  logic [3:0]         crn,
  input  logic [3:0]         crm,
  input  logic [2:0]         op2,
  input  logic [NUM_CTR-1:0] userAccessMask,
  input  logic [CNT_W-1:0]   implCount,
  input  logic [CNT_W-1:0]   accCount,
  input  accessDecision_t    dec,
  output accessCond_t        cond,
  output logic               outValid,
  output logic [2:0]         outKind,
  output logic [1:0]         trapLevel,
  output logic [7:0]         syndromeClass,
  output logic [IDX_W-1:0]   counterIdx
);

  localparam int IDX_SPAN = 1 << IDX_W;

  logic [IDX_W-1:0]    idx;
  logic [CNT_W-1:0]    idxWide;
  logic [IDX_SPAN-1:0] maskPad;
  logic                slotOver;

  assign idx     = {crm[1:0], op2};
  assign idxWide = CNT_W'(idx);

  for (genvar i = 0; i < IDX_SPAN; i++) begin : g_mask
    if (i < NUM_CTR) begin : g_live
      assign maskPad[i] = userAccessMask[i];
    end else begin : g_pad
      assign maskPad[i] = 1'b0;
    end
  end

  assign slotOver = idxWide >= CNT_W'(NUM_CTR);

  always_comb begin
    cond.match    = (op0 == SEL_OP0) && (op1 == SEL_OP1) && (crn == SEL_CRN)
                    && (crm[3:2] == SEL_CRM_TOP);
    cond.overImpl = slotOver || (idxWide >= implCount);
    cond.overAcc  = idxWide >= accCount;
    cond.userBit  = maskPad[idx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outKind       <= 3'd0;
      trapLevel     <= 2'd0;
      syndromeClass <= 8'd0;
      counterIdx    <= '0;
    end else if (inValid && cond.match) begin
      outValid      <= 1'b1;
      outKind       <= dec.kind;
      trapLevel     <= dec.trapLevel;
      syndromeClass <= dec.isTrap ? SYN_CLASS : 8'd0;
      counterIdx    <= idx;
    end else begin
      outValid      <= 1'b0;
      outKind       <= 3'd0;
      trapLevel     <= 2'd0;
      syndromeClass <= 8'd0;
      counterIdx    <= '0;
    end
  end

  assert_index_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cond.match) |=> (outValid && counterIdx == $past({crm[1:0], op2})));

  assert_no_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && cond.match) |=> (!outValid && outKind == 3'd0 && syndromeClass == 8'd0));

  assert_undef_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cond.match && cond.overImpl) |=> (outKind == KIND_UNDEF));

  assert_trap_class_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == KIND_TRAP) |-> (syndromeClass == SYN_CLASS && trapLevel != 2'd0));

  assert_quiet_class_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outKind != KIND_TRAP) |-> (syndromeClass == 8'd0 && trapLevel == 2'd0));

endmodule

// File: rtl/ctrcfg_ctrl.sv
module ctrcfg_ctrl
  import ctrcfg_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  accessCond_t     cond,
  input  logic            isRead,
  input  logic [1:0]      curLevel,
  input  logic            el2Enabled,
  input  logic            hostRedirect,
  input  logic            userEnAll,
  input  logic            userEnMasked,
  input  logic            userReadOnly,
  input  logic            fgRdTrap,
  input  logic            fgWrTrap,
  input  logic            l2MonTrap,
  input  logic            l3MonTrap,
  output accessDecision_t dec
);

  logic fgTrap;
  logic userBlocked;
  logic l2Hit;
  logic maskedRaz;
  logic maskedWi;

  assign fgTrap      = isRead ? fgRdTrap : fgWrTrap;
  assign userBlocked = !userEnAll && !userEnMasked;
  // level-2 chain: fine-grained, then monitor, then accessible range
  assign l2Hit       = el2Enabled && (fgTrap || l2MonTrap || cond.overAcc);
  assign maskedRaz   = userEnMasked && isRead && !cond.userBit;
  assign maskedWi    = userEnMasked && !isRead && (!cond.userBit || userReadOnly);

  always_comb begin
    dec.kind      = KIND_PERFORM;
    dec.trapLevel = 2'd0;
    dec.isTrap    = 1'b0;
    if (cond.overImpl) begin
      dec.kind = KIND_UNDEF;
    end else begin
      unique case (curLevel)
        2'd0: begin
          if (userBlocked) begin
            dec.kind      = KIND_TRAP;
            dec.isTrap    = 1'b1;
            dec.trapLevel = (el2Enabled && hostRedirect) ? 2'd2 : 2'd1;
          end else if (l2Hit) begin
            dec.kind      = KIND_TRAP;
            dec.isTrap    = 1'b1;
            dec.trapLevel = 2'd2;
          end else if (l3MonTrap) begin
            dec.kind      = KIND_TRAP;
            dec.isTrap    = 1'b1;
            dec.trapLevel = 2'd3;
          end else if (maskedRaz) begin
            dec.kind = KIND_RAZ;
          end else if (maskedWi) begin
            dec.kind = KIND_WI;
          end
        end
        2'd1: begin
          if (l2Hit) begin
            dec.kind      = KIND_TRAP;
            dec.isTrap    = 1'b1;
            dec.trapLevel = 2'd2;
          end else if (l3MonTrap) begin
            dec.kind      = KIND_TRAP;
            dec.isTrap    = 1'b1;
            dec.trapLevel = 2'd3;
          end
        end
        2'd2: begin
          if (l3MonTrap) begin
            dec.kind      = KIND_TRAP;
            dec.isTrap    = 1'b1;
            dec.trapLevel = 2'd3;
          end
        end
        default: dec.kind = KIND_PERFORM;
      endcase
    end
  end

  assert_trap_upward_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dec.kind == KIND_TRAP) |-> (dec.trapLevel > curLevel));

  assert_top_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    (curLevel == 2'd3 && !cond.overImpl) |-> (dec.kind == KIND_PERFORM));

  assert_user_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dec.kind == KIND_RAZ || dec.kind == KIND_WI) |-> (curLevel == 2'd0 && userEnMasked));

endmodule

// File: rtl/ctrcfg_access_check.sv
module ctrcfg_access_check
  import ctrcfg_pkg::*;
#(
  parameter int NUM_CTR = 31,
  parameter int IDX_W = 5,
  parameter int CNT_W = IDX_W + 1,
  parameter logic [7:0] SYN_CLASS = 8'h18
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [1:0]         op0,
  input  logic [2:0]         op1,
  input  logic [3:0]         crn,
  input  logic [3:0]         crm,
  input  logic [2:0]         op2,
  input  logic               isRead,
  input  logic [1:0]         curLevel,
  input  logic               el2Enabled,
  input  logic               hostRedirect,
  input  logic               userEnAll,
  input  logic               userEnMasked,
  input  logic               userReadOnly,
  input  logic [NUM_CTR-1:0] userAccessMask,
  input  logic               fgRdTrap,
  input  logic               fgWrTrap,
  input  logic               l2MonTrap,
  input  logic               l3MonTrap,
  input  logic [CNT_W-1:0]   implCount,
  input  logic [CNT_W-1:0]   accCount,
  output logic               outValid,
  output logic [2:0]         outKind,
  output logic [1:0]         trapLevel,
  output logic [7:0]         syndromeClass,
  output logic [IDX_W-1:0]   counterIdx
);

  accessCond_t     cond;
  accessDecision_t dec;

  ctrcfg_decode #(
    .NUM_CTR(NUM_CTR), .IDX_W(IDX_W), .CNT_W(CNT_W), .SYN_CLASS(SYN_CLASS)
  ) u_decode (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2),
    .userAccessMask(userAccessMask), .implCount(implCount), .accCount(accCount),
    .dec(dec), .cond(cond),
    .outValid(outValid), .outKind(outKind), .trapLevel(trapLevel),
    .syndromeClass(syndromeClass), .counterIdx(counterIdx)
  );

  ctrcfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cond(cond), .isRead(isRead), .curLevel(curLevel),
    .el2Enabled(el2Enabled), .hostRedirect(hostRedirect),
    .userEnAll(userEnAll), .userEnMasked(userEnMasked), .userReadOnly(userReadOnly),
    .fgRdTrap(fgRdTrap), .fgWrTrap(fgWrTrap),
    .l2MonTrap(l2MonTrap), .l3MonTrap(l3MonTrap), .dec(dec)
  );

endmodule

// File: tb/ctrcfg_access_check_tb.sv
`timescale 1ns/1ps
module ctrcfg_access_check_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] op0 = 2'b11;
  logic [2:0] op1 = 3'b011;
  logic [3:0] crn = 4'b1110;
  logic [3:0] crm = 4'b1100;
  logic [2:0] op2 = 3'd0;
  logic isRead = 1'b1;
  logic [1:0] curLevel = 2'd0;
  logic el2Enabled = 1'b0, hostRedirect = 1'b0;
  logic userEnAll = 1'b1, userEnMasked = 1'b0, userReadOnly = 1'b0;
  logic [30:0] userAccessMask = '1;
  logic fgRdTrap = 1'b0, fgWrTrap = 1'b0, l2MonTrap = 1'b0, l3MonTrap = 1'b0;
  logic [5:0] implCount = 6'd31, accCount = 6'd31;
  logic outValid;
  logic [2:0] outKind;
  logic [1:0] trapLevel;
  logic [7:0] syndromeClass;
  logic [4:0] counterIdx;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ctrcfg_access_check u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2),
    .isRead(isRead), .curLevel(curLevel), .el2Enabled(el2Enabled),
    .hostRedirect(hostRedirect), .userEnAll(userEnAll), .userEnMasked(userEnMasked),
    .userReadOnly(userReadOnly), .userAccessMask(userAccessMask),
    .fgRdTrap(fgRdTrap), .fgWrTrap(fgWrTrap), .l2MonTrap(l2MonTrap),
    .l3MonTrap(l3MonTrap), .implCount(implCount), .accCount(accCount),
    .outValid(outValid), .outKind(outKind), .trapLevel(trapLevel),
    .syndromeClass(syndromeClass), .counterIdx(counterIdx)
  );

  // Reference model of the requirements: packs {valid, kind, level, class, idx}
  function automatic logic [18:0] expect_out(output string tag);
    logic match;
    int idx;
    logic fg;
    logic [2:0] k;
    logic [1:0] lv;
    match = inValid && op0 == 2'b11 && op1 == 3'b011 && crn == 4'b1110 && crm[3:2] == 2'b11;
    idx = {crm[1:0], op2};
    fg = isRead ? fgRdTrap : fgWrTrap;
    k = 3'd0;
    lv = 2'd0;
    tag = "R6";
    if (!match) begin
      tag = "R8";
      return '0;
    end
    if (idx >= 31 || idx >= int'(implCount)) begin
      tag = "R2";
      k = 3'd3;
    end else if (curLevel == 2'd0 && !userEnAll && !userEnMasked) begin
      tag = "R3";
      k = 3'd4;
      lv = (el2Enabled && hostRedirect) ? 2'd2 : 2'd1;
    end else if (curLevel <= 2'd1 && el2Enabled && (fg || l2MonTrap || idx >= int'(accCount))) begin
      tag = "R5";
      k = 3'd4;
      lv = 2'd2;
    end else if (curLevel <= 2'd2 && l3MonTrap) begin
      tag = (curLevel == 2'd2) ? "R6" : "R5";
      k = 3'd4;
      lv = 2'd3;
    end else if (curLevel == 2'd0 && userEnMasked && isRead && !userAccessMask[idx]) begin
      tag = "R7";
      k = 3'd1;
    end else if (curLevel == 2'd0 && userEnMasked && !isRead && (!userAccessMask[idx] || userReadOnly)) begin
      tag = "R7";
      k = 3'd2;
    end else if (curLevel == 2'd0 && userEnMasked) begin
      tag = "R7";
    end
    return {1'b1, k, lv, (k == 3'd4) ? 8'h18 : 8'h00, 5'(idx)};
  endfunction

  task automatic check_now(input logic [18:0] exp, input string tag);
    logic [18:0] act;
    act = {outValid, outKind, trapLevel, syndromeClass, counterIdx};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got v=%0b kind=%0d lvl=%0d cls=%h idx=%0d expected v=%0b kind=%0d lvl=%0d cls=%h idx=%0d",
               tag, act[18], act[17:15], act[14:13], act[12:5], act[4:0],
               exp[18], exp[17:15], exp[14:13], exp[12:5], exp[4:0]);
    end
  endtask

  // Inputs are already set at a falling edge; one rising edge, then compare
  task automatic apply();
    logic [18:0] exp;
    string tag;
    exp = expect_out(tag);
    @(posedge clk);
    @(negedge clk);
    check_now(exp, tag);
  endtask

  task automatic set_idx(input int i);
    crm = {2'b11, 2'(i >> 3)};
    op2 = 3'(i);
  endtask

  task automatic quiet();
    inValid = 1'b1; op0 = 2'b11; op1 = 3'b011; crn = 4'b1110; set_idx(0);
    isRead = 1'b1; curLevel = 2'd0; el2Enabled = 1'b0; hostRedirect = 1'b0;
    userEnAll = 1'b1; userEnMasked = 1'b0; userReadOnly = 1'b0; userAccessMask = '1;
    fgRdTrap = 1'b0; fgWrTrap = 1'b0; l2MonTrap = 1'b0; l3MonTrap = 1'b0;
    implCount = 6'd31; accCount = 6'd31;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    check_now('0, "R8 reset");
    rstN = 1'b1;
    @(negedge clk);

    // R1: index formation, level 3 performs
    quiet(); curLevel = 2'd3; set_idx(13); apply();
    quiet(); curLevel = 2'd3; set_idx(30); apply();
    // R8: mismatched encoding and idle
    quiet(); crn = 4'b1101; apply();
    quiet(); crm = 4'b1011; apply();
    quiet(); inValid = 1'b0; apply();
    // R2: boundary indices and priority over everything
    quiet(); curLevel = 2'd3; set_idx(31); apply();
    quiet(); curLevel = 2'd0; userEnAll = 1'b0; l3MonTrap = 1'b1; implCount = 6'd8; set_idx(8); apply();
    quiet(); implCount = 6'd8; set_idx(7); apply();
    // R3: user enables clear
    quiet(); userEnAll = 1'b0; apply();
    quiet(); userEnAll = 1'b0; el2Enabled = 1'b1; hostRedirect = 1'b1; apply();
    quiet(); userEnAll = 1'b0; hostRedirect = 1'b1; apply();
    // R5: chain at level 1, wrong-direction fine-grained bit ignored
    quiet(); curLevel = 2'd1; el2Enabled = 1'b1; fgWrTrap = 1'b1; isRead = 1'b1; apply();
    quiet(); curLevel = 2'd1; el2Enabled = 1'b1; fgWrTrap = 1'b1; isRead = 1'b0; l3MonTrap = 1'b1; apply();
    quiet(); curLevel = 2'd1; el2Enabled = 1'b1; accCount = 6'd4; set_idx(4); apply();
    quiet(); curLevel = 2'd1; el2Enabled = 1'b0; l2MonTrap = 1'b1; accCount = 6'd0; l3MonTrap = 1'b1; apply();
    // R6: level 2 ignores level-2 controls
    quiet(); curLevel = 2'd2; el2Enabled = 1'b1; l2MonTrap = 1'b1; fgRdTrap = 1'b1; apply();
    quiet(); curLevel = 2'd2; l3MonTrap = 1'b1; apply();
    // R7: masked user access
    quiet(); userEnMasked = 1'b1; userAccessMask = 31'h7fff_dfff; set_idx(13); apply();
    quiet(); userEnMasked = 1'b1; isRead = 1'b0; userAccessMask = 31'h7fff_dfff; set_idx(13); apply();
    quiet(); userEnMasked = 1'b1; isRead = 1'b0; userReadOnly = 1'b1; set_idx(5); apply();
    quiet(); userEnMasked = 1'b1; isRead = 1'b0; set_idx(5); apply();
    quiet(); userEnMasked = 1'b1; userEnAll = 1'b0; isRead = 1'b1; userReadOnly = 1'b1; set_idx(2); apply();

    // Random traffic, R1..R8 via the reference model
    for (int n = 0; n < 3000; n++) begin
      quiet();
      inValid = ($urandom % 8) != 0;
      if (($urandom % 8) == 0) begin
        op0 = 2'($urandom); op1 = 3'($urandom); crn = 4'($urandom);
      end
      crm = ($urandom % 8 == 0) ? 4'($urandom) : {2'b11, 2'($urandom)};
      op2 = 3'($urandom);
      isRead = 1'($urandom);
      curLevel = 2'($urandom);
      el2Enabled = 1'($urandom);
      hostRedirect = 1'($urandom);
      userEnAll = ($urandom % 4) == 0;
      userEnMasked = ($urandom % 4) != 0;
      userReadOnly = ($urandom % 4) == 0;
      userAccessMask = 31'($urandom);
      fgRdTrap = ($urandom % 4) == 0;
      fgWrTrap = ($urandom % 4) == 0;
      l2MonTrap = ($urandom % 4) == 0;
      l3MonTrap = ($urandom % 4) == 0;
      implCount = ($urandom % 2) ? 6'd31 : 6'($urandom);
      accCount = ($urandom % 2) ? 6'd31 : 6'($urandom);
      apply();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule